// File: doc/BRIEF.md
# Serial Converter Command-Frame Responder

This block models the digital serial face of a two-channel, 10-bit data converter. It behaves as a serial-peripheral-interface slave. An external master lowers chip select and then clocks in a short command: a start bit, an input-mode bit, a channel bit and an output-order bit. The block then clocks out the conversion result for the chosen channel. Two parallel input ports stand in for the analog core and supply one result word per channel. The block latches the chosen word once per frame, so the master reads a value that stays consistent for the whole frame.

The block samples all serial pins in one system clock domain. Each pin passes through a two-flop synchroniser, and edge detection follows it. The system clock must run at least four times faster than the serial clock. Both serial-clock idle levels work: mode 0,0 (idle low) and mode 1,1 (idle high). The slave takes data on rising serial-clock edges. It changes its output only after falling edges.

The frame state machine has these states:
- IDLE: chip select is high.
- WAIT_START: chip select is low and no start bit has arrived yet.
- GET_MODE, GET_CHAN, GET_ORDER: each captures one command bit on a rising edge.
- LATCH_WAIT: the result word is captured on the next falling edge.
- NULL_BIT: a 0 is on the line before the result.
- SHIFT_FWD: the result goes out most significant bit first.
- SHIFT_REV: the result goes out again, least significant bit first.
- TAIL: the line stays at 0.

The transitions are:
- IDLE→WAIT_START when chip select falls.
- WAIT_START→GET_MODE on a rising edge with data-in high.
- GET_MODE→GET_CHAN, GET_CHAN→GET_ORDER and GET_ORDER→LATCH_WAIT, each on a rising edge.
- LATCH_WAIT→NULL_BIT on a falling edge.
- NULL_BIT→SHIFT_FWD on a falling edge.
- SHIFT_FWD→TAIL on the falling edge after bit 0 when the order bit is 1.
- SHIFT_FWD→SHIFT_REV on that same falling edge when the order bit is 0.
- SHIFT_REV→TAIL on the falling edge after bit 9.
- Any state→IDLE when chip select rises.

Top module: `sadc_frame_slave`

## Requirements
- R1: While chip select (csn_in) is high, miso_oe is 0 and miso_out is 0. While chip select is low, miso_oe is 1.
- R2: After chip select falls, rising serial-clock edges with mosi_in at 0 are skipped. The first rising edge with mosi_in at 1 is the start bit, and it counts as clock 1 of the frame.
- R3: The mosi_in bit on clock 2 selects the input mode: 1 is single-ended and 0 is pseudo-differential. cmd_single reports it and holds it until the next frame's clock 2.
- R4: The mosi_in bit on clock 3 selects the channel: 0 picks ch0_result and 1 picks ch1_result. cmd_chan reports it.
- R5: The mosi_in bit on clock 4 selects the output order: 1 sends the result most significant bit first only, and 0 adds the reversed copy of R10.
- R6: The chosen channel's word is latched on the falling serial edge after clock 4. Changes on ch0_result or ch1_result after that edge do not alter the bits sent in the frame.
- R7: miso_out, sampled just before each rising edge, is 0 on clocks 1 to 5. Clock 5 carries the null bit.
- R8: Clocks 6 to 15 carry result bits 9 down to 0, so clock c carries bit 15−c. miso_out changes only after a falling serial edge.
- R9: With order bit 1, miso_out is 0 on clock 16 and on every later clock of the frame.
- R10: With order bit 0, clocks 16 to 24 carry result bits 1 to 9, so clock c carries bit c−15. Bit 0 is not repeated. Later clocks carry 0.
- R11: Raising chip select at any clock ends the frame. The next frame again waits for a start bit and runs in full.
- R12: Modes 0,0 and 1,1 give the same frame. A serial-clock edge while chip select is high, or a falling edge before the start bit, has no effect.
- R13: After reset, miso_out, miso_oe, cmd_single and cmd_chan are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4× the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_in | input | 1 | Serial clock from the master |
| csn_in | input | 1 | Active-low chip select from the master |
| mosi_in | input | 1 | Serial command data from the master |
| ch0_result | input | 10 | Result word standing in for channel 0 |
| ch1_result | input | 10 | Result word standing in for channel 1 |
| miso_out | output | 1 | Serial result data to the master |
| miso_oe | output | 1 | Output enable for miso_out |
| cmd_single | output | 1 | Last captured mode bit (1 = single-ended) |
| cmd_chan | output | 1 | Last captured channel bit |

## Verification
A state machine that enters a state one edge early or late shifts every result bit by one clock. The bench sees this on clock 6 as a wrong most significant bit, or on clock 5 as a nonzero null bit. A wrong capture of the channel or order bit shows by clock 6 or clock 16, where the bench reads the other channel's word or the missing reversed copy. A latch taken at the wrong moment, or a failure to return to IDLE when chip select rises, shows at the first differing bit of that frame or of the frame after the abort.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_WAIT_START,
        S_GET_MODE,
        S_GET_CHAN,
        S_GET_ORDER,
        S_LATCH_WAIT,
        S_NULL_BIT,
        S_SHIFT_FWD,
        S_SHIFT_REV,
        S_TAIL
    } frame_state_e;

endpackage

// File: rtl/sadc_sync.sv
// Multi-stage synchroniser for a bundle of asynchronous pins.
module sadc_sync #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    localparam int CHAIN_W = WIDTH * STAGES;

    logic [CHAIN_W-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain <= {chain[CHAIN_W-WIDTH-1:0], d};
        end
    end

    assign q = chain[CHAIN_W-1 -: WIDTH];
endmodule

// File: rtl/sadc_edge_det.sv
// Turns a synchronised serial clock into rise and fall pulses.
module sadc_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise,
    output logic fall
);
    logic level_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_d <= 1'b0;
        end else begin
            level_d <= level;
        end
    end

    assign rise = level & ~level_d;
    assign fall = ~level & level_d;
endmodule

// File: rtl/sadc_result_hold.sv
// Picks the commanded channel and freezes its word for the frame.
module sadc_result_hold #(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [RES_W-1:0] ch0_val,
    input  logic [RES_W-1:0] ch1_val,
    input  logic             chan_sel,
    input  logic             capture,
    output logic [RES_W-1:0] held
);
    logic [RES_W-1:0] picked;

    assign picked = chan_sel ? ch1_val : ch0_val;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held <= '0;
        end else if (capture) begin
            held <= picked;
        end
    end
endmodule

// File: rtl/sadc_frame_fsm.sv
// Command decode and result sequencing for one chip-select frame.
module sadc_frame_fsm
    import sadc_pkg::*;
#(
    parameter int RES_W = 10,
    localparam int IDX_W = $clog2(RES_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_act,
    input  logic             sclk_rise,
    input  logic             sclk_fall,
    input  logic             din,
    input  logic [RES_W-1:0] held,
    output frame_state_e     state,
    output logic             mode_se,
    output logic             chan_sel,
    output logic             order_msb,
    output logic             capture,
    output logic             dout,
    output logic [IDX_W-1:0] bit_idx
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(RES_W - 1);
    localparam logic [IDX_W-1:0] ZERO_IDX = '0;

    frame_state_e nxt;

    // next-state decode
    always_comb begin
        nxt = state;
        if (!cs_act) begin
            nxt = S_IDLE;
        end else begin
            unique case (state)
                S_IDLE:       nxt = S_WAIT_START;
                S_WAIT_START: if (sclk_rise && din) nxt = S_GET_MODE;
                S_GET_MODE:   if (sclk_rise) nxt = S_GET_CHAN;
                S_GET_CHAN:   if (sclk_rise) nxt = S_GET_ORDER;
                S_GET_ORDER:  if (sclk_rise) nxt = S_LATCH_WAIT;
                S_LATCH_WAIT: if (sclk_fall) nxt = S_NULL_BIT;
                S_NULL_BIT:   if (sclk_fall) nxt = S_SHIFT_FWD;
                S_SHIFT_FWD: begin
                    if (sclk_fall && bit_idx == ZERO_IDX) begin
                        nxt = order_msb ? S_TAIL : S_SHIFT_REV;
                    end
                end
                S_SHIFT_REV: begin
                    if (sclk_fall && bit_idx == LAST_IDX) nxt = S_TAIL;
                end
                S_TAIL:       nxt = S_TAIL;
                default:      nxt = S_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= nxt;
        end
    end

    assign capture = cs_act && sclk_fall && (state == S_LATCH_WAIT);

    // outputs and captured command bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout      <= 1'b0;
            bit_idx   <= '0;
            mode_se   <= 1'b0;
            chan_sel  <= 1'b0;
            order_msb <= 1'b0;
        end else if (!cs_act) begin
            dout    <= 1'b0;
            bit_idx <= '0;
        end else begin
            unique case (state)
                S_GET_MODE:  if (sclk_rise) mode_se   <= din;
                S_GET_CHAN:  if (sclk_rise) chan_sel  <= din;
                S_GET_ORDER: if (sclk_rise) order_msb <= din;
                S_LATCH_WAIT: if (sclk_fall) dout <= 1'b0;
                S_NULL_BIT: begin
                    if (sclk_fall) begin
                        dout    <= held[LAST_IDX];
                        bit_idx <= LAST_IDX;
                    end
                end
                S_SHIFT_FWD: begin
                    if (sclk_fall) begin
                        if (bit_idx == ZERO_IDX) begin
                            if (order_msb) begin
                                dout <= 1'b0;
                            end else begin
                                bit_idx <= IDX_W'(1);
                                dout    <= held[1];
                            end
                        end else begin
                            bit_idx <= bit_idx - 1'b1;
                            dout    <= held[bit_idx - 1'b1];
                        end
                    end
                end
                S_SHIFT_REV: begin
                    if (sclk_fall) begin
                        if (bit_idx == LAST_IDX) begin
                            dout <= 1'b0;
                        end else begin
                            bit_idx <= bit_idx + 1'b1;
                            dout    <= held[bit_idx + 1'b1];
                        end
                    end
                end
                S_TAIL: dout <= 1'b0;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/sadc_frame_slave.sv
module sadc_frame_slave
    import sadc_pkg::*;
#(
    parameter int RES_W       = 10,
    parameter int SYNC_STAGES = 2,
    localparam int IDX_W      = $clog2(RES_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk_in,
    input  logic             csn_in,
    input  logic             mosi_in,
    input  logic [RES_W-1:0] ch0_result,
    input  logic [RES_W-1:0] ch1_result,
    output logic             miso_out,
    output logic             miso_oe,
    output logic             cmd_single,
    output logic             cmd_chan
);
    logic             sclk_s;
    logic             csn_s;
    logic             din_s;
    logic             cs_act;
    logic             sclk_rise;
    logic             sclk_fall;
    logic [RES_W-1:0] held_val;
    logic             chan_sel;
    logic             order_msb;
    logic             capture;
    logic             dout;
    logic [IDX_W-1:0] bit_idx;
    frame_state_e     fsm_state;

    sadc_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b010)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sclk_in, csn_in, mosi_in}),
        .q     ({sclk_s, csn_s, din_s})
    );

    assign cs_act = ~csn_s;

    sadc_edge_det u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (sclk_s),
        .rise  (sclk_rise),
        .fall  (sclk_fall)
    );

    sadc_result_hold #(.RES_W(RES_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .ch0_val  (ch0_result),
        .ch1_val  (ch1_result),
        .chan_sel (chan_sel),
        .capture  (capture),
        .held     (held_val)
    );

    sadc_frame_fsm #(.RES_W(RES_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_act    (cs_act),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .din       (din_s),
        .held      (held_val),
        .state     (fsm_state),
        .mode_se   (cmd_single),
        .chan_sel  (chan_sel),
        .order_msb (order_msb),
        .capture   (capture),
        .dout      (dout),
        .bit_idx   (bit_idx)
    );

    assign cmd_chan = chan_sel;
    assign miso_oe  = cs_act;
    assign miso_out = cs_act & dout;
endmodule

// File: rtl/sadc_frame_checker.sv
module sadc_frame_checker
    import sadc_pkg::*;
#(
    parameter int RES_W  = 10,
    localparam int IDX_W = $clog2(RES_W)
) (
    input logic             clk,
    input logic             rst_n,
    input frame_state_e     state,
    input logic             sclk_rise,
    input logic             sclk_fall,
    input logic             din_s,
    input logic [RES_W-1:0] held,
    input logic [IDX_W-1:0] bit_idx,
    input logic             miso_out,
    input logic             miso_oe
);
    // R1: nothing is driven while deselected
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |-> (miso_out == 1'b0));

    // R2: leaving the wait only on a rising edge with data high
    assert_start_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_GET_MODE && $past(state) == S_WAIT_START)
            |-> $past(sclk_rise && din_s));

    // R6: the frozen word moves only on the latch edge
    assert_hold_only_at_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(held) |-> ($past(state) == S_LATCH_WAIT && $past(sclk_fall)));

    // R8: data out moves only after a falling serial edge
    assert_dout_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (miso_oe && $past(miso_oe) && !$stable(miso_out)) |-> $past(sclk_fall));

    // R8: shift index stays inside the word
    assert_idx_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        int'(bit_idx) < RES_W);

    // R9: line stays low once the frame has run out of bits
    assert_tail_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_TAIL) |-> (miso_out == 1'b0));
endmodule

bind sadc_frame_slave sadc_frame_checker #(.RES_W(RES_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (fsm_state),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .din_s     (din_s),
    .held      (held_val),
    .bit_idx   (bit_idx),
    .miso_out  (miso_out),
    .miso_oe   (miso_oe)
);

// File: tb/sadc_frame_slave_test.sv
module sadc_frame_slave_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk_in = 1'b0;
    logic       csn_in = 1'b1;
    logic       mosi_in = 1'b0;
    logic [9:0] ch0_result = '0;
    logic [9:0] ch1_result = '0;
    logic       miso_out;
    logic       miso_oe;
    logic       cmd_single;
    logic       cmd_chan;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    localparam int HALF = 8;   // system clocks per serial half period

    always #10 clk = ~clk;     // 50 MHz

    sadc_frame_slave uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_in    (sclk_in),
        .csn_in     (csn_in),
        .mosi_in    (mosi_in),
        .ch0_result (ch0_result),
        .ch1_result (ch1_result),
        .miso_out   (miso_out),
        .miso_oe    (miso_oe),
        .cmd_single (cmd_single),
        .cmd_chan   (cmd_chan)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    // behavioural expectation for serial clock c of the frame
    function automatic logic exp_bit(input int c, input logic [9:0] r, input bit ord);
        if (c <= 5) return 1'b0;
        if (c <= 15) return r[15 - c];
        if (ord) return 1'b0;
        if (c <= 24) return r[c - 15];
        return 1'b0;
    endfunction

    function automatic string bit_tag(input int c, input bit ord);
        if (c <= 0) return "R2";
        if (c <= 5) return "R7";
        if (c <= 15) return "R8";
        return ord ? "R9" : "R10";
    endfunction

    task automatic run_frame(input string ftag, input int lead, input bit md, input bit ch,
                             input bit ord, input int nclk, input bit cpol,
                             input logic [9:0] v0, input logic [9:0] v1, input bit disturb);
        logic [9:0] res;
        int total;
        res = ch ? v1 : v0;
        total = lead + nclk;
        ch0_result = v0;
        ch1_result = v1;
        mosi_in = 1'b0;
        sclk_in = cpol;
        csn_in = 1'b1;
        wait_clks(2 * HALF);
        csn_in = 1'b0;
        wait_clks(HALF);
        chk({ftag, " R1 oe while selected"}, 16'(miso_oe), 16'd1);
        if (cpol) begin
            sclk_in = 1'b0;
            wait_clks(HALF);
        end
        for (int k = 1; k <= total; k++) begin
            int c;
            c = k - lead;
            mosi_in = (c == 1) ? 1'b1 : (c == 2) ? md : (c == 3) ? ch : (c == 4) ? ord : 1'b0;
            wait_clks(HALF);
            chk($sformatf("%s %s clock %0d", ftag,
                          (disturb && c > 7) ? "R6" : bit_tag(c, ord), c),
                16'(miso_out), (c <= 0) ? 16'd0 : 16'(exp_bit(c, res, ord)));
            sclk_in = 1'b1;
            wait_clks(HALF);
            if (disturb && c == 7) begin
                ch0_result = ~v0;
                ch1_result = ~v1;
            end
            if (k != total) sclk_in = 1'b0;
        end
        if (!cpol) sclk_in = 1'b0;
        wait_clks(HALF);
        csn_in = 1'b1;
        mosi_in = 1'b0;
        wait_clks(HALF);
        chk({ftag, " R1 oe after deselect"}, 16'(miso_oe), 16'd0);
        chk({ftag, " R1 data after deselect"}, 16'(miso_out), 16'd0);
        if (nclk >= 4) begin
            chk({ftag, " R3 mode report"}, 16'(cmd_single), 16'(md));
            chk({ftag, " R4 channel report"}, 16'(cmd_chan), 16'(ch));
        end
    endtask

    // R12: serial clock toggling while deselected must leave the outputs idle
    task automatic toggle_deselected();
        csn_in = 1'b1;
        for (int k = 0; k < 4; k++) begin
            sclk_in = ~sclk_in;
            mosi_in = ~mosi_in;
            wait_clks(HALF);
            chk("R12 deselected toggling", 16'({miso_oe, miso_out}), 16'd0);
        end
        mosi_in = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<=150000 cycles", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        wait_clks(5);
        rst_n = 1'b1;
        wait_clks(2);
        // R13 reset state
        chk("R13 miso_oe", 16'(miso_oe), 16'd0);
        chk("R13 miso_out", 16'(miso_out), 16'd0);
        chk("R13 cmd_single", 16'(cmd_single), 16'd0);
        chk("R13 cmd_chan", 16'(cmd_chan), 16'd0);

        // R5 order=1, channel 0, single-ended
        run_frame("F1", 0, 1'b1, 1'b0, 1'b1, 16, 1'b0, 10'h2A5, 10'h15A, 1'b0);
        // R2 leading zeros, R10 reversed copy, channel 1, pseudo-differential
        run_frame("F2", 3, 1'b0, 1'b1, 1'b0, 26, 1'b0, 10'h3C1, 10'h2B7, 1'b0);
        toggle_deselected();
        // R12 mode 1,1, R6 inputs disturbed during shift
        run_frame("F3", 1, 1'b1, 1'b1, 1'b1, 20, 1'b1, 10'h0F0, 10'h19B, 1'b1);
        // R11 abort mid-result, then a full frame
        run_frame("F4", 0, 1'b0, 1'b0, 1'b0, 9, 1'b0, 10'h155, 10'h0AA, 1'b0);
        run_frame("F5 R11", 0, 1'b1, 1'b0, 1'b0, 25, 1'b0, 10'h001, 10'h3FF, 1'b0);
        // R12 mode 1,1 with reversal and all-ones word
        run_frame("F6", 2, 1'b0, 1'b1, 1'b0, 26, 1'b1, 10'h000, 10'h3FF, 1'b1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule